// File: doc/BRIEF.md
# Reference clock loss supervisor

This block runs on a free-running local oscillator clock and watches a slower reference clock. The reference passes through a two-flop synchronizer, and a rising-edge detector restarts a gap counter on every reference edge. The block also measures each reference period in local cycles and keeps the last accepted period. From this it decides whether the loop counts as locked. It drives an unlock flag and an enable decision that a downstream clock gate uses.

The block has two ways to lose lock. If the reference stops cleanly, the block waits through a long cycle-count timeout before it declares unlock. If the reference shows a period shorter or longer than the stored one by more than a tolerance, the block declares unlock at once. A skip-enable bit can tolerate one long gap: when it is set and the gap is at least a minimum skip length, the block stays locked and keeps its stored period. After an unlock, the first reference edge starts a lock-time count, and lock is declared when that count ends. While the block is unlocked, a configuration bit chooses whether the downstream clock is gated off or passed through.

Top module: `refclk_supervisor`

## Requirements
- R1: After reset, unlock_o is 1, and it stays 1 for at least LOCK_CYC local cycles. out_en_o is 0 while unl_pass_i is 0.
- R2: After the first synchronized reference rising edge, unlock_o stays 1 while LOCK_CYC local cycles elapse. It then falls to 0, provided the reference keeps toggling.
- R3: While locked, unlock_o stays 0 until 2^TMO_W-1 local cycles pass with no synchronized reference rising edge. It then becomes 1 on the next cycle, whatever the value of skip_en_i.
- R4: While locked, a reference period shorter than the stored period by more than TOL cycles sets unlock_o on the cycle after that edge is detected. No timeout is waited out.
- R5: While locked with skip_en_i=0, a reference period longer than the stored period by more than TOL cycles sets unlock_o at once.
- R6: While locked with skip_en_i=1, a long period of at least SKIP_MIN cycles leaves unlock_o at 0, and the stored period is left unchanged.
- R7: While locked with skip_en_i=1, a long period (beyond TOL) that is shorter than SKIP_MIN cycles still sets unlock_o at once.
- R8: A period within TOL cycles of the stored period keeps the block locked and becomes the new stored period.
- R9: out_en_o is 1 while locked. While unlocked it equals unl_pass_i: 0 gates the clock off and 1 passes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| unl_pass_i | input | 1 | Output behaviour while unlocked: 0 gate off, 1 pass |
| skip_en_i | input | 1 | Tolerate a long reference gap of at least SKIP_MIN cycles |
| unlock_o | output | 1 | 1 while the loop counts as unlocked |
| out_en_o | output | 1 | Enable for the downstream clock gate |

## Verification
The bench builds the block with TMO_W=8, LOCK_CYC=40, TOL=2 and SKIP_MIN=20, and drives a reference with a nominal period of 10 local cycles. With an 8-bit timeout, a clean stop reaches unlock after about 255 cycles rather than millions. This lets the bench sample both sides of the timeout in one short run. The small lock time lets the bench relock between scenarios. The chosen tolerance and skip minimum let a single inserted gap of 6, 30 or 50 cycles fall below the skip minimum, trigger a non-skipped unlock, or be skipped.

// File: rtl/refsup_pkg.sv
package refsup_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // unlocked, waiting for reference activity
    ST_ACQ  = 2'd1,  // counting the lock time
    ST_LOCK = 2'd2
  } lock_state_e;
endpackage

// File: rtl/refsup_edge_sync.sv
module refsup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/refsup_period_meter.sv
module refsup_period_meter #(
  parameter int TMO_W    = 23,
  parameter int TOL      = 2,
  parameter int SKIP_MIN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic skip_en_i,
  output logic tmo_o,
  output logic bad_o
);
  localparam int PW = TMO_W + 1;
  localparam logic [PW:0]   TOL_V  = (PW+1)'(TOL);
  localparam logic [PW-1:0] SKIP_V = PW'(SKIP_MIN);

  logic [TMO_W-1:0] gap_q;
  logic [PW-1:0]    per_q, new_per;
  logic             per_vld_q;
  logic             too_short, too_long, skip_ok;

  assign new_per   = {1'b0, gap_q} + PW'(1);
  assign too_short = per_vld_q && (({1'b0, new_per} + TOL_V) < {1'b0, per_q});
  assign too_long  = per_vld_q && ({1'b0, new_per} > ({1'b0, per_q} + TOL_V));
  assign skip_ok   = too_long && skip_en_i && (new_per >= SKIP_V);
  assign bad_o     = too_short || (too_long && !skip_ok);
  assign tmo_o     = &gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      per_q     <= '0;
      per_vld_q <= 1'b0;
    end else if (rise_i) begin
      gap_q <= '0;
      if (!skip_ok) begin
        per_q     <= new_per;
        per_vld_q <= !tmo_o;
      end
    end else if (tmo_o) begin
      per_vld_q <= 1'b0;
    end else begin
      gap_q <= gap_q + TMO_W'(1);
    end
  end
endmodule

// File: rtl/refsup_lock_ctrl.sv
module refsup_lock_ctrl
  import refsup_pkg::*;
#(
  parameter int LOCK_CYC = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic tmo_i,
  input  logic bad_i,
  output logic locked_o
);
  localparam int CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(LOCK_CYC - 1);

  lock_state_e      st_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_WAIT: if (rise_i) begin
          st_q  <= ST_ACQ;
          cnt_q <= '0;
        end
        ST_ACQ: begin
          if (tmo_i)                 st_q <= ST_WAIT;
          else if (cnt_q == CNT_END) st_q <= ST_LOCK;
          else                       cnt_q <= cnt_q + CW'(1);
        end
        ST_LOCK: if (tmo_i || (rise_i && bad_i)) st_q <= ST_WAIT;
        default: st_q <= ST_WAIT;
      endcase
    end
  end

  assign locked_o = (st_q == ST_LOCK);
endmodule

// File: rtl/refclk_supervisor.sv
module refclk_supervisor #(
  parameter int TMO_W    = 23,
  parameter int LOCK_CYC = 65536,
  parameter int TOL      = 2,
  parameter int SKIP_MIN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic unl_pass_i,
  input  logic skip_en_i,
  output logic unlock_o,
  output logic out_en_o
);
  logic rise, tmo, bad, locked;

  refsup_edge_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .async_i(ref_clk_i), .rise_o(rise)
  );

  refsup_period_meter #(.TMO_W(TMO_W), .TOL(TOL), .SKIP_MIN(SKIP_MIN)) i_meter (
    .clk_i, .rst_ni, .rise_i(rise), .skip_en_i, .tmo_o(tmo), .bad_o(bad)
  );

  refsup_lock_ctrl #(.LOCK_CYC(LOCK_CYC)) i_lock (
    .clk_i, .rst_ni, .rise_i(rise), .tmo_i(tmo), .bad_i(bad), .locked_o(locked)
  );

  assign unlock_o = !locked;
  assign out_en_o = locked | unl_pass_i;
endmodule

// File: rtl/refsup_checker.sv
module refsup_checker #(
  parameter int LOCK_CYC = 65536
) (
  input logic clk_i,
  input logic rst_ni,
  input logic unl_pass_i,
  input logic unlock_o,
  input logic out_en_o,
  input logic tmo,
  input logic rise,
  input logic bad
);
  localparam int RW = $clog2(LOCK_CYC + 1) + 1;
  logic [RW-1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_rst_q <= '0;
    else if (since_rst_q < RW'(LOCK_CYC)) since_rst_q <= since_rst_q + RW'(1);
  end

  AST_RESET_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < RW'(LOCK_CYC)) |-> unlock_o); // R1
  AST_TIMEOUT_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> unlock_o); // R3
  AST_BAD_EDGE_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlock_o && rise && bad) |=> unlock_o); // R4
  AST_LOCKED_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_o |-> out_en_o); // R9
  AST_UNLOCKED_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> (out_en_o == unl_pass_i)); // R9
endmodule

bind refclk_supervisor refsup_checker #(.LOCK_CYC(LOCK_CYC)) i_chk (
  .clk_i, .rst_ni, .unl_pass_i, .unlock_o, .out_en_o, .tmo, .rise, .bad
);

// File: tb/test_refclk_supervisor.sv
module test_refclk_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic unl_pass = 1'b0;
  logic skip_en = 1'b0;
  logic unlock, out_en;

  int checks = 0, errors = 0;
  bit done = 0;
  bit run = 0;
  int hi_c = 5, lo_c = 5, extra = 0;

  always #2 clk = ~clk;

  refclk_supervisor #(.TMO_W(8), .LOCK_CYC(40), .TOL(2), .SKIP_MIN(20)) i_refclk_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .unl_pass_i(unl_pass),
    .skip_en_i(skip_en), .unlock_o(unlock), .out_en_o(out_en)
  );

  // reference generator, all changes on the falling local edge
  initial begin
    forever begin
      if (run) begin
        repeat (extra) @(negedge clk);
        extra = 0;
        ref_clk = 1'b1;
        repeat (hi_c) @(negedge clk);
        ref_clk = 1'b0;
        repeat (lo_c) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic relock(input string req);
    int n = 0;
    while (unlock && n < 600) begin
      @(negedge clk);
      n++;
    end
    check(req, unlock, 1'b0, "relock");
  endtask

  task automatic t_reset;
    check("R1", unlock, 1'b1, "unlock at reset");
    check("R1", out_en, 1'b0, "out_en at reset");
  endtask

  task automatic t_acquire;
    hi_c = 5; lo_c = 5; run = 1;
    wait_cyc(30);
    check("R2", unlock, 1'b1, "unlock during lock time");
    wait_cyc(30);
    check("R2", unlock, 1'b0, "unlock after lock time");
    check("R9", out_en, 1'b1, "out_en while locked");
  endtask

  task automatic t_clean_stop(input logic skip);
    skip_en = skip;
    run = 0;
    wait_cyc(200);
    check("R3", unlock, 1'b0, "unlock before timeout");
    wait_cyc(100);
    check("R3", unlock, 1'b1, "unlock after timeout");
    check("R9", out_en, 1'b0, "out_en gated while unlocked");
    unl_pass = 1'b1;
    wait_cyc(1);
    check("R9", out_en, 1'b1, "out_en passed while unlocked");
    unl_pass = 1'b0;
    skip_en = 1'b0;
    run = 1;
    relock("R2");
  endtask

  task automatic t_short_period;
    hi_c = 2; lo_c = 2;
    wait_cyc(20);
    check("R4", unlock, 1'b1, "unlock on short period");
    hi_c = 5; lo_c = 5;
    wait_cyc(20);
    relock("R2");
  endtask

  task automatic t_long_gap(input logic skip, input int gap, input logic exp, input string req);
    skip_en = skip;
    wait_cyc(20);
    extra = gap;
    wait_cyc(gap + 30);
    check(req, unlock, exp, "unlock after long gap");
    if (!exp) begin
      wait_cyc(100);
      check(req, unlock, 1'b0, "still locked after skipped gap");
    end
    skip_en = 1'b0;
    relock(req);
  endtask

  task automatic t_tolerance;
    lo_c = 6;
    wait_cyc(100);
    check("R8", unlock, 1'b0, "locked after period 11");
    lo_c = 7;
    wait_cyc(100);
    check("R8", unlock, 1'b0, "locked after period 12 tracks stored");
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_acquire();
    t_clean_stop(1'b0);
    t_clean_stop(1'b1);
    t_short_period();
    t_long_gap(1'b0, 30, 1'b1, "R5");
    t_long_gap(1'b1, 6, 1'b1, "R7");
    t_long_gap(1'b1, 50, 1'b0, "R6");
    t_tolerance();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule